// File: doc/BRIEF.md
# TDM Slot-Masked Serial Receiver

This block is the receive half of a synchronous serial port that runs in time-division-multiplexed network mode. A frame-sync pulse marks the first bit of slot 0. The block then cuts the serial bit stream into fixed-length words, one word per time slot, for a configurable number of slots per frame (1 to 32). A 32-bit slot-enable mask decides which slots are captured. In an enabled slot, the finished word goes into a holding register and raises a receive-full condition. In a disabled slot, nothing is captured, no flag moves and no interrupt is raised. The block also drops its data-input enable for the length of a disabled slot.

The host sees four registers on a 24-bit bus: the low mask half, the high mask half, the receive data register and a control/status word. Mask writes go into a staging copy. That copy becomes the active mask only when the next frame starts, so a frame in progress always completes under one consistent mask. The block reads the bit clock, frame sync and serial data with its own system clock. It captures a bit on each falling edge of the bit clock, most significant bit first.

Top module: `tdm_slot_rx`

## Requirements
- R1: The 32-bit slot mask is built from two 16-bit registers. Register address 0 holds the enables for slots 0 to 15 and address 1 holds the enables for slots 16 to 31. Mask bit n enables slot n.
- R2: When a slot's active mask bit is 0, its word is discarded. The data register keeps its old value, the full flag and the overrun flag do not get set, and the interrupt line does not rise.
- R3: When a slot's active mask bit is 1, the completed word is written to the data register at the end of the slot and the full flag (status bit 0) is set.
- R4: Inside a running frame, `din_en` is low throughout a slot whose active mask bit is 0 and high throughout a slot whose bit is 1.
- R5: A mask write takes no effect in the frame in progress. The staged value becomes the active mask only at the next frame start.
- R6: A read of address 0 or 1 returns the last value written to that register, not the active copy. The mask occupies bits 15:0 and bits 23:16 read as 0.
- R7: After reset, both mask registers and the active mask are all ones. The full and overrun flags and the interrupt enable are 0, the data register is 0 and `rx_irq` is low.
- R8: A bit is captured on each falling edge of `bit_clk`. If `frame_sync` is high at that edge, the bit is the MSB of slot 0. Each slot is WORD_W bits, MSB first. After SLOTS slots the block ignores bits until the next frame sync.
- R9: If an enabled slot completes while the full flag is 1, the overrun flag (status bit 1) is set and the new word replaces the data register.
- R10: A read of the data register (address 2) clears the full flag. The overrun flag is cleared only by a data read that follows a status read (address 3) made while overrun was set. A data read alone leaves overrun set.
- R11: `rx_irq` is high exactly while the full flag is 1 and the interrupt-enable bit (bit 8 of address 3, read/write) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock; a bit is captured on its falling edge |
| frame_sync | input | 1 | High during the first bit of slot 0 |
| ser_din | input | 1 | Serial receive data, MSB first |
| din_en | output | 1 | Data-input enable; low during disabled slots |
| host_addr | input | 2 | Register select: 0 mask low, 1 mask high, 2 data, 3 control/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; drives the read side effects |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Host read data for the selected register |
| rx_irq | output | 1 | Receive-full interrupt request |

## Verification
A wrong bit or slot counter shows up within one frame. Words come back shifted or rotated, or land in the wrong slot, and the next data read after the misplaced slot shows it. An active mask that copies from the staging register at the wrong moment makes the data register or the full flag change in a slot where the staged mask says it should not, no later than the end of that slot. Wrong flag sequencing shows at the status read that follows the triggering slot: overrun missing or cleared too early, or a full flag the data read left set. Wrong interrupt gating shows on `rx_irq` one cycle after the flag or enable change.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int MAX_SLOTS  = 32;
    localparam int HALF_W     = 16;
    localparam int BUS_W      = 24;
    localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);

    // Host register select
    typedef enum logic [1:0] {
        REG_MASK_LO = 2'd0,
        REG_MASK_HI = 2'd1,
        REG_DATA    = 2'd2,
        REG_CTRL    = 2'd3
    } reg_sel_e;

    // Bit positions inside the control/status word
    localparam int CTRL_FULL_BIT = 0;
    localparam int CTRL_OVR_BIT  = 1;
    localparam int CTRL_IE_BIT   = 8;

    typedef struct packed {
        logic overrun;
        logic full;
    } rx_flags_t;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } slot_mask_t;

    function automatic logic [MAX_SLOTS-1:0] mask_word(slot_mask_t m);
        return {m.hi, m.lo};
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
    import tdm_rx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_clk,
    input  logic                  frame_sync,
    output logic                  frame_start,
    output logic                  sample_stb,
    output logic                  word_done,
    output logic                  live,
    output logic [SLOT_IDX_W-1:0] slot_idx
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]      LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(SLOTS - 1);

    logic             bclk_q;
    logic             fall;
    logic [BIT_W-1:0] bit_idx;

    assign fall        = bclk_q & ~bit_clk;
    assign frame_start = fall & frame_sync;
    assign sample_stb  = fall & (frame_sync | live);
    assign word_done   = fall & ~frame_sync & live & (bit_idx == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            bit_idx  <= '0;
            slot_idx <= '0;
            live     <= 1'b0;
        end else begin
            bclk_q <= bit_clk;
            if (frame_start) begin
                live     <= 1'b1;
                slot_idx <= '0;
                bit_idx  <= BIT_W'(1);
            end else if (fall && live) begin
                if (bit_idx == LAST_BIT) begin
                    bit_idx <= '0;
                    if (slot_idx == LAST_SLOT) begin
                        live <= 1'b0;
                    end else begin
                        slot_idx <= slot_idx + 1'b1;
                    end
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_shift_in.sv
module tdm_shift_in #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic              ser_din,
    output logic [WORD_W-1:0] word_next
);

    // Only WORD_W-1 bits are kept; the final bit joins combinationally.
    logic [WORD_W-2:0] shreg;

    assign word_next = {shreg, ser_din};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sample_stb) begin
            shreg <= word_next[WORD_W-2:0];
        end
    end

endmodule

// File: rtl/tdm_slot_mask.sv
module tdm_slot_mask
    import tdm_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wdata,
    input  logic                  frame_start,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    output slot_mask_t            staged,
    output logic [MAX_SLOTS-1:0]  active_mask,
    output logic                  slot_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged      <= '1;
            active_mask <= '1;
        end else begin
            if (wr_lo) staged.lo <= wdata;
            if (wr_hi) staged.hi <= wdata;
            // A write in the same cycle lands in the stage for the frame after.
            if (frame_start) active_mask <= mask_word(staged);
        end
    end

    assign slot_en = active_mask[slot_idx];

endmodule

// File: rtl/tdm_rx_status.sv
module tdm_rx_status
    import tdm_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_data,
    input  logic              rd_ctrl,
    input  logic              wr_ctrl,
    input  logic              ie_in,
    output logic [WORD_W-1:0] data_q,
    output rx_flags_t         flags,
    output logic              irq_en,
    output logic              irq
);

    logic clr_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            flags     <= '0;
            irq_en    <= 1'b0;
            clr_armed <= 1'b0;
        end else begin
            if (wr_ctrl) irq_en <= ie_in;
            if (rd_ctrl) clr_armed <= flags.overrun;
            if (load) begin
                data_q     <= word_in;
                flags.full <= 1'b1;
                if (flags.full && !rd_data) begin
                    flags.overrun <= 1'b1;
                end else if (rd_data && clr_armed) begin
                    flags.overrun <= 1'b0;
                end
            end else if (rd_data) begin
                flags.full <= 1'b0;
                if (clr_armed) flags.overrun <= 1'b0;
            end
            if (rd_data) clr_armed <= 1'b0;
        end
    end

    assign irq = flags.full & irq_en;

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SLOTS  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_clk,
    input  logic             frame_sync,
    input  logic             ser_din,
    output logic             din_en,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic             rx_irq
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(host_addr);

    logic wr_lo, wr_hi, wr_ctrl, rd_data, rd_ctrl;
    assign wr_lo   = host_wr && (sel == REG_MASK_LO);
    assign wr_hi   = host_wr && (sel == REG_MASK_HI);
    assign wr_ctrl = host_wr && (sel == REG_CTRL);
    assign rd_data = host_rd && (sel == REG_DATA);
    assign rd_ctrl = host_rd && (sel == REG_CTRL);

    logic unused_wdata;
    assign unused_wdata = ^host_wdata[BUS_W-1:HALF_W];

    logic                  frame_start, sample_stb, word_done, live;
    logic [SLOT_IDX_W-1:0] slot_idx;

    tdm_bit_timer #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .bit_clk     (bit_clk),
        .frame_sync  (frame_sync),
        .frame_start (frame_start),
        .sample_stb  (sample_stb),
        .word_done   (word_done),
        .live        (live),
        .slot_idx    (slot_idx)
    );

    logic [WORD_W-1:0] word_next;

    tdm_shift_in #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .ser_din    (ser_din),
        .word_next  (word_next)
    );

    slot_mask_t           staged;
    logic [MAX_SLOTS-1:0] active_mask;
    logic                 slot_en;

    tdm_slot_mask u_mask (
        .clk         (clk),
        .rst         (rst),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .wdata       (host_wdata[HALF_W-1:0]),
        .frame_start (frame_start),
        .slot_idx    (slot_idx),
        .staged      (staged),
        .active_mask (active_mask),
        .slot_en     (slot_en)
    );

    logic [WORD_W-1:0] data_q;
    rx_flags_t         flags;
    logic              irq_en;

    tdm_rx_status #(.WORD_W(WORD_W)) u_status (
        .clk     (clk),
        .rst     (rst),
        .load    (word_done && slot_en),
        .word_in (word_next),
        .rd_data (rd_data),
        .rd_ctrl (rd_ctrl),
        .wr_ctrl (wr_ctrl),
        .ie_in   (host_wdata[CTRL_IE_BIT]),
        .data_q  (data_q),
        .flags   (flags),
        .irq_en  (irq_en),
        .irq     (rx_irq)
    );

    assign din_en = live && slot_en;

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            REG_MASK_LO: host_rdata = BUS_W'(staged.lo);
            REG_MASK_HI: host_rdata = BUS_W'(staged.hi);
            REG_DATA:    host_rdata = BUS_W'(data_q);
            REG_CTRL: begin
                host_rdata[CTRL_FULL_BIT] = flags.full;
                host_rdata[CTRL_OVR_BIT]  = flags.overrun;
                host_rdata[CTRL_IE_BIT]   = irq_en;
            end
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              word_done,
    input logic              slot_en,
    input logic              frame_start,
    input logic              rd_data,
    input logic              wr_ctrl,
    input logic              full,
    input logic              overrun,
    input logic              rx_irq,
    input logic [WORD_W-1:0] data_q,
    input logic [31:0]       active_mask,
    input logic [1:0]        host_addr,
    input logic [23:0]       host_rdata
);

    assert_disabled_keeps_data_R2: assert property (@(posedge clk) disable iff (rst)
        (word_done && !slot_en) |=> $stable(data_q));

    assert_disabled_no_overrun_R2: assert property (@(posedge clk) disable iff (rst)
        (word_done && !slot_en && !overrun) |=> !overrun);

    assert_enabled_sets_full_R3: assert property (@(posedge clk) disable iff (rst)
        (word_done && slot_en) |=> full);

    assert_mask_frozen_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active_mask));

    assert_mask_read_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (host_addr[1] == 1'b0) |-> (host_rdata[23:16] == 8'h00));

    assert_overrun_on_full_R9: assert property (@(posedge clk) disable iff (rst)
        (word_done && slot_en && full && !rd_data) |=> overrun);

    assert_irq_needs_full_R11: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> full);

    assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> ($past(word_done && slot_en) || $past(wr_ctrl)));

endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_done   (word_done),
    .slot_en     (slot_en),
    .frame_start (frame_start),
    .rd_data     (rd_data),
    .wr_ctrl     (wr_ctrl),
    .full        (flags.full),
    .overrun     (flags.overrun),
    .rx_irq      (rx_irq),
    .data_q      (data_q),
    .active_mask (active_mask),
    .host_addr   (host_addr),
    .host_rdata  (host_rdata)
);

// File: tb/tdm_slot_rx_tb.sv
`timescale 1ns/1ps
module tdm_slot_rx_tb;

    localparam int WORD_W = 8;
    localparam int SLOTS  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        frame_sync = 1'b0;
    logic        ser_din = 1'b0;
    logic        din_en;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [23:0] host_wdata = '0;
    logic [23:0] host_rdata;
    logic        rx_irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tdm_slot_rx #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bit_clk    (bit_clk),
        .frame_sync (frame_sync),
        .ser_din    (ser_din),
        .din_en     (din_en),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rx_irq     (rx_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [23:0] v);
        @(negedge clk);
        host_addr = a;
        host_rd   = 1'b1;
        #1;
        v = host_rdata;
        @(negedge clk);
        host_rd   = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic fs);
        @(negedge clk);
        bit_clk    = 1'b1;
        ser_din    = b;
        frame_sync = fs;
        repeat (2) @(negedge clk);
        bit_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Sends one slot; en_seen is din_en observed after the slot's first bit.
    task automatic send_slot(input int s, input logic [WORD_W-1:0] w, output logic en_seen);
        en_seen = 1'b0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            send_bit(w[b], (s == 0) && (b == WORD_W - 1));
            if (b == WORD_W - 1) en_seen = din_en;
        end
        frame_sync = 1'b0;
    endtask

    function automatic logic [31:0] pattern(input int k);
        logic [31:0] base;
        int r;
        if (k == 0) return 32'hFFFF_FFFF;
        if (k == 1) return 32'h0000_0000;
        base = 32'hA5C3_1E69;
        r = (k * 3) % 32;
        return ((base << r) | (base >> (32 - r))) ^ 32'(k);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [23:0]       v;
        logic              en;
        logic [WORD_W-1:0] last;
        logic [31:0]       m;
        logic [WORD_W-1:0] w;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R7 reset state
        chk("R7", "irq after reset", 32'(rx_irq), 32'd0);
        host_read(2'd0, v); chk("R7", "mask lo after reset", 32'(v), 32'h00FFFF);
        host_read(2'd1, v); chk("R7", "mask hi after reset", 32'(v), 32'h00FFFF);
        host_read(2'd3, v); chk("R7", "ctrl after reset", 32'(v), 32'd0);
        host_read(2'd2, v); chk("R7", "data after reset", 32'(v), 32'd0);

        // R6 readback of staged value, upper byte zero
        host_write(2'd1, 24'hAB1234);
        host_read(2'd1, v); chk("R6", "mask hi readback", 32'(v), 32'h001234);
        host_write(2'd0, 24'hFFFFFF);
        host_read(2'd0, v); chk("R6", "mask lo readback", 32'(v), 32'h00FFFF);

        // Sweep of mask patterns: R1 R2 R3 R4 R8
        last = '0;
        for (int k = 0; k < 14; k++) begin
            m = pattern(k);
            host_write(2'd0, {8'h00, m[15:0]});
            host_write(2'd1, {8'h00, m[31:16]});
            for (int s = 0; s < SLOTS; s++) begin
                w = WORD_W'(k * 37 + s * 11 + 5);
                send_slot(s, w, en);
                chk("R4", $sformatf("din_en k=%0d slot=%0d", k, s), 32'(en), 32'(m[s]));
                host_read(2'd3, v);
                chk(m[s] ? "R3" : "R2", $sformatf("full k=%0d slot=%0d", k, s),
                    32'(v[0]), 32'(m[s]));
                chk("R2", $sformatf("overrun k=%0d slot=%0d", k, s), 32'(v[1]), 32'd0);
                if (m[s]) last = w;
                host_read(2'd2, v);
                chk("R8", $sformatf("data k=%0d slot=%0d", k, s), 32'(v), 32'(last));
                chk("R1", $sformatf("irq off k=%0d slot=%0d", k, s), 32'(rx_irq), 32'd0);
            end
        end

        // R8: bits after the last slot with no frame sync are ignored
        host_write(2'd0, 24'h00FFFF);
        host_write(2'd1, 24'h00FFFF);
        send_slot(1, 8'h99, en);
        host_read(2'd3, v); chk("R8", "no capture past last slot", 32'(v[0]), 32'd0);

        // R5: write during a frame is deferred
        for (int s = 0; s < SLOTS; s++) begin
            w = WORD_W'(8'h40 + s);
            send_slot(s, w, en);
            if (s == 1) begin
                host_write(2'd0, 24'h000000);
                host_write(2'd1, 24'h000000);
                host_read(2'd0, v); chk("R6", "staged value visible", 32'(v), 32'd0);
            end
            host_read(2'd3, v);
            chk("R5", $sformatf("old mask holds slot=%0d", s), 32'(v[0]), 32'd1);
            host_read(2'd2, v);
            chk("R5", $sformatf("old mask data slot=%0d", s), 32'(v), 32'(w));
            last = w;
        end
        for (int s = 0; s < 3; s++) begin
            send_slot(s, 8'hE0, en);
            chk("R5", $sformatf("new mask din_en slot=%0d", s), 32'(en), 32'd0);
            host_read(2'd3, v);
            chk("R5", $sformatf("new mask blocks slot=%0d", s), 32'(v[0]), 32'd0);
        end
        host_read(2'd2, v); chk("R2", "data kept under zero mask", 32'(v), 32'(last));

        // R9 / R10: overrun and its clearing sequence
        host_write(2'd0, 24'h000003);
        send_slot(0, 8'h3C, en);
        send_slot(1, 8'hC3, en);
        host_read(2'd2, v); chk("R9", "overrun overwrites data", 32'(v), 32'h0000C3);
        host_read(2'd3, v);
        chk("R9", "overrun set", 32'(v[1]), 32'd1);
        chk("R10", "data read clears full", 32'(v[0]), 32'd0);
        chk("R10", "data read alone keeps overrun", 32'(v[1]), 32'd1);
        host_read(2'd2, v);
        host_read(2'd3, v); chk("R10", "status then data clears overrun", 32'(v[1]), 32'd0);

        // R2: disabled slot after a full word sets neither overrun nor data
        host_write(2'd0, 24'h000001);
        send_slot(2, 8'h11, en);
        send_slot(0, 8'h5A, en);
        send_slot(1, 8'hA5, en);
        host_read(2'd3, v);
        chk("R2", "disabled slot no overrun", 32'(v[1]), 32'd0);
        chk("R3", "full still from slot 0", 32'(v[0]), 32'd1);
        chk("R11", "irq low with enable off", 32'(rx_irq), 32'd0);

        // R11: interrupt gating
        host_write(2'd3, 24'h000100);
        chk("R11", "irq on after enable", 32'(rx_irq), 32'd1);
        host_read(2'd3, v); chk("R11", "ctrl with enable", 32'(v), 32'h000101);
        host_read(2'd2, v); chk("R2", "disabled slot left data", 32'(v), 32'h00005A);
        chk("R11", "irq off after data read", 32'(rx_irq), 32'd0);
        send_slot(0, 8'h77, en);
        chk("R11", "irq on new word", 32'(rx_irq), 32'd1);
        host_read(2'd2, v); chk("R3", "new word data", 32'(v), 32'h000077);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule